// File: doc/BRIEF.md
# Vector Single-Precision to BFloat16 Narrowing Converter

This unit takes a 128-bit source vector of four single-precision lanes and narrows each lane to a 16-bit BFloat16 value. The four results are packed into a 64-bit half, and that half is merged into a 128-bit destination value. The surrounding pipeline provides the old destination contents. It receives the merged value back, together with a flag that reports an undefined operation.

A select bit picks one of two write forms:

- **Low form.** The packed half goes into the bottom of the destination and the top half is cleared.
- **High form.** The packed half goes into the top of the destination and the bottom half is kept as it was.

The surrounding pipeline reads the destination as four narrow lanes after a low-form write and as eight narrow lanes after a high-form write.

Each lane's conversion follows two runtime controls: a rounding selector and a denormal-flush bit. When the feature-enable input is low, the unit flags the operation as undefined and returns the old destination without change. By default one output register follows the combinational datapath, and a valid input is accepted on every cycle.

Top module: `fp32_bf16_narrow`

## Requirements
- R1: Result lane e (bits 16e+15..16e of the packed half, e = 0..3) is the conversion of source bits 32e+31..32e.
- R2: With upperSel = 0 and the feature enabled, newDst[63:0] holds the packed half and newDst[127:64] is zero.
- R3: With upperSel = 1 and the feature enabled, newDst[127:64] holds the packed half and newDst[63:0] equals the old destination's bits 63..0.
- R4: With bf16Enable = 0, undefOp is 1 and newDst equals oldDst unchanged; with bf16Enable = 1, undefOp is 0.
- R5: With roundMode = 0 (nearest-even), a lane rounds up when its dropped low 16 bits exceed 0x8000, or equal 0x8000 while bit 16 is 1; otherwise it keeps the upper 16 bits.
- R6: With roundMode = 1 (toward zero), a non-NaN lane result is source bits 31..16 of that lane.
- R7: A NaN lane (exponent all ones, mantissa non-zero) yields sign, exponent 0xFF, mantissa bit 6 forced to 1, and mantissa bits 5..0 taken from source bits 21..16. It never becomes infinity.
- R8: Infinities and zeros of either sign convert exactly (0x7F800000 gives 0x7F80, 0x80000000 gives 0x8000).
- R9: Under nearest-even, a finite value that rounds past 0x7F7F (magnitude) becomes infinity of the same sign.
- R10: A denormal lane (exponent zero, mantissa non-zero) gives signed zero when flushDenorm = 1. When flushDenorm = 0 it is rounded like any other value.
- R11: After reset, outValid, undefOp and newDst are 0. With the output register enabled, outValid and the results appear one cycle after inValid, and outValid is 0 in the cycle after an idle input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| srcVec | input | 128 | Four single-precision source lanes |
| oldDst | input | 128 | Current destination register value |
| upperSel | input | 1 | 0: low form, 1: high form |
| roundMode | input | 1 | 0: nearest-even, 1: toward zero |
| flushDenorm | input | 1 | Flush denormal inputs to signed zero |
| bf16Enable | input | 1 | Feature enable; 0 makes the operation undefined |
| outValid | output | 1 | Result valid |
| newDst | output | 128 | Merged destination value |
| undefOp | output | 1 | Undefined-operation flag |

## Verification
The bench builds the unit with its defaults: four lanes of 32 bits narrowed to 16, and the output register enabled. That configuration makes the one-cycle latency, the held-output behaviour and the valid-drop case observable at the ports. The clocked properties that compare the new destination with the previous cycle's old destination apply only to the registered variant, so they are active as well. Random lanes are mixed with NaNs, infinities, zeros, denormals and round-to-tie patterns, so the special paths are reached under both rounding modes and both write forms.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

  typedef enum logic {
    RND_NEAREST_EVEN = 1'b0,
    RND_TOWARD_ZERO  = 1'b1
  } roundSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic undef;     // feature disabled: report and hold destination
    logic writeLow;  // low form: packed half to bottom, clear top
    logic writeHigh; // high form: packed half to top, keep bottom
  } strobe_t;

endpackage

// File: rtl/narrow_lane.sv
module narrow_lane
  import narrow_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int EXP_W = 8
) (
  input  logic [IN_W-1:0]  opIn,
  input  roundSel_e        roundMode,
  input  logic             flushDenorm,
  output logic [OUT_W-1:0] resOut
);
  localparam int MAN_W   = IN_W - 1 - EXP_W;
  localparam int OMAN_W  = OUT_W - 1 - EXP_W;
  localparam int DROP_W  = IN_W - OUT_W;
  localparam logic [IN_W-1:0] HALF_ULP = IN_W'({(DROP_W-1){1'b1}});

  logic             sgn;
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             isNan, isInfOrZero, isSub;
  logic [IN_W-1:0]  roundSum;
  logic [OUT_W-1:0] nanRes;

  assign sgn      = opIn[IN_W-1];
  assign expField = opIn[IN_W-2 -: EXP_W];
  assign manField = opIn[MAN_W-1:0];

  assign isNan       = (&expField) && (|manField);
  assign isInfOrZero = ((&expField) || ~(|expField)) && ~(|manField);
  assign isSub       = ~(|expField) && (|manField);

  // bias below half an output ulp, plus the kept lsb for ties-to-even
  assign roundSum = opIn + HALF_ULP + IN_W'(opIn[DROP_W]);

  assign nanRes = {sgn, {EXP_W{1'b1}}, 1'b1, manField[MAN_W-2 -: OMAN_W-1]};

  always_comb begin
    if (isNan)                     resOut = nanRes;
    else if (isInfOrZero)          resOut = opIn[IN_W-1 -: OUT_W];
    else if (isSub && flushDenorm) resOut = {sgn, {(OUT_W-1){1'b0}}};
    else if (roundMode == RND_TOWARD_ZERO) resOut = opIn[IN_W-1 -: OUT_W];
    else                           resOut = roundSum[IN_W-1 -: OUT_W];
  end

  always_comb begin
    if (isNan) begin
      assert_nan_stays_quiet_R7: assert (&resOut[OUT_W-2 -: EXP_W] && resOut[OMAN_W-1]);
    end
  end

endmodule

// File: rtl/narrow_ctrl.sv
module narrow_ctrl
  import narrow_pkg::*;
(
  input  logic    inValid,
  input  logic    upperSel,
  input  logic    bf16Enable,
  output strobe_t strb
);
  always_comb begin
    strb           = '0;
    strb.load      = inValid;
    strb.undef     = inValid && !bf16Enable;
    strb.writeLow  = inValid && bf16Enable && !upperSel;
    strb.writeHigh = inValid && bf16Enable && upperSel;
  end
endmodule

// File: rtl/narrow_datapath.sv
module narrow_datapath
  import narrow_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int IN_W    = 32,
  parameter int OUT_W   = 16,
  parameter int EXP_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [LANES*IN_W-1:0]  srcVec,
  input  logic [LANES*IN_W-1:0]  oldDst,
  input  roundSel_e              roundMode,
  input  logic                   flushDenorm,
  output logic                   outValid,
  output logic [LANES*IN_W-1:0]  newDst,
  output logic                   undefOp
);
  localparam int VEC_W  = LANES * IN_W;
  localparam int HALF_W = LANES * OUT_W;

  logic [HALF_W-1:0] packedHalf;
  logic [VEC_W-1:0]  nextDst;

  for (genvar e = 0; e < LANES; e++) begin : gLane
    narrow_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) uLane (
      .opIn       (srcVec[e*IN_W +: IN_W]),
      .roundMode  (roundMode),
      .flushDenorm(flushDenorm),
      .resOut     (packedHalf[e*OUT_W +: OUT_W])
    );
  end

  always_comb begin
    nextDst = oldDst;
    if (strb.writeLow)
      nextDst = {{(VEC_W-HALF_W){1'b0}}, packedHalf};
    else if (strb.writeHigh)
      nextDst = {packedHalf, oldDst[VEC_W-HALF_W-1:0]};
  end

  if (REG_OUT) begin : gReg
    logic [VEC_W-1:0] dstQ;
    logic             validQ, undefQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dstQ   <= '0;
        validQ <= 1'b0;
        undefQ <= 1'b0;
      end else begin
        validQ <= strb.load;
        undefQ <= strb.undef;
        if (strb.load) dstQ <= nextDst;
      end
    end

    assign newDst   = dstQ;
    assign outValid = validQ;
    assign undefOp  = undefQ;

    assert_low_clears_top_R2: assert property (@(posedge clk) disable iff (!rstN)
      strb.writeLow |=> (newDst[VEC_W-1:HALF_W] == '0 && !undefOp));
    assert_high_keeps_bottom_R3: assert property (@(posedge clk) disable iff (!rstN)
      strb.writeHigh |=> (newDst[HALF_W-1:0] == $past(oldDst[HALF_W-1:0])));
    assert_undef_holds_dst_R4: assert property (@(posedge clk) disable iff (!rstN)
      strb.undef |=> (undefOp && newDst == $past(oldDst)));
    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
      strb.load |=> outValid);
    assert_idle_drops_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
      !strb.load |=> (!outValid && !undefOp));
  end else begin : gComb
    assign newDst   = nextDst;
    assign outValid = strb.load;
    assign undefOp  = strb.undef;
  end

endmodule

// File: rtl/fp32_bf16_narrow.sv
module fp32_bf16_narrow
  import narrow_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int IN_W    = 32,
  parameter int OUT_W   = 16,
  parameter int EXP_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [LANES*IN_W-1:0] srcVec,
  input  logic [LANES*IN_W-1:0] oldDst,
  input  logic                  upperSel,
  input  logic                  roundMode,
  input  logic                  flushDenorm,
  input  logic                  bf16Enable,
  output logic                  outValid,
  output logic [LANES*IN_W-1:0] newDst,
  output logic                  undefOp
);
  strobe_t strb;

  narrow_ctrl uCtrl (
    .inValid   (inValid),
    .upperSel  (upperSel),
    .bf16Enable(bf16Enable),
    .strb      (strb)
  );

  narrow_datapath #(
    .LANES(LANES), .IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W), .REG_OUT(REG_OUT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .srcVec     (srcVec),
    .oldDst     (oldDst),
    .roundMode  (roundSel_e'(roundMode)),
    .flushDenorm(flushDenorm),
    .outValid   (outValid),
    .newDst     (newDst),
    .undefOp    (undefOp)
  );
endmodule

// File: tb/sim_fp32_bf16_narrow.sv
module sim_fp32_bf16_narrow;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid, upperSel, roundMode, flushDenorm, bf16Enable;
  logic [127:0] srcVec, oldDst;
  logic         outValid, undefOp;
  logic [127:0] newDst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_bf16_narrow u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec), .oldDst(oldDst),
    .upperSel(upperSel), .roundMode(roundMode), .flushDenorm(flushDenorm),
    .bf16Enable(bf16Enable), .outValid(outValid), .newDst(newDst), .undefOp(undefOp)
  );

  function automatic logic [15:0] refLane(logic [31:0] x, bit rtz, bit ftz);
    logic [15:0] hi;
    logic [15:0] lo;
    hi = x[31:16];
    lo = x[15:0];
    if (x[30:23] == 8'hFF && x[22:0] != 0) return {x[31], 8'hFF, 1'b1, x[21:16]};
    if (x[30:23] == 8'h00 && x[22:0] != 0 && ftz) return {x[31], 15'd0};
    if (rtz) return hi;
    if (lo > 16'h8000 || (lo == 16'h8000 && hi[0])) return hi + 16'd1;
    return hi;
  endfunction

  function automatic logic [127:0] refDst(logic [127:0] src, logic [127:0] old,
                                           bit sel, bit en, bit rtz, bit ftz);
    logic [63:0] half;
    if (!en) return old;
    for (int e = 0; e < 4; e++) half[e*16 +: 16] = refLane(src[e*32 +: 32], rtz, ftz);
    return sel ? {half, old[63:0]} : {64'd0, half};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(string req, logic [127:0] src, logic [127:0] old,
                       bit sel, bit en, bit rtz, bit ftz);
    inValid = 1'b1; srcVec = src; oldDst = old; upperSel = sel;
    bf16Enable = en; roundMode = rtz; flushDenorm = ftz;
    @(posedge clk); @(negedge clk);
    check(req, newDst, refDst(src, old, sel, en, rtz, ftz));
    check({req, " undef"}, {127'd0, undefOp}, {127'd0, !en});
    check({req, " valid R11"}, {127'd0, outValid}, 128'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] oldPat;
    void'($urandom(32'd2718));
    oldPat = 128'hA5A5_5A5A_1234_5678_9ABC_DEF0_0F0F_F0F0;
    rstN = 1'b0; inValid = 1'b0; srcVec = '0; oldDst = '0; upperSel = 1'b0;
    roundMode = 1'b0; flushDenorm = 1'b0; bf16Enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset newDst", newDst, 128'd0);
    check("R11 reset valid", {127'd0, outValid}, 128'd0);
    check("R11 reset undef", {127'd0, undefOp}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 lane order, explicit expected value
    apply("R1 lanes", {32'h3F000000, 32'hC0400000, 32'h40000000, 32'h3F800000}, oldPat, 0, 1, 0, 0);
    check("R1 literal", newDst, {64'd0, 64'h3F00_C040_4000_3F80});
    // R2 low form clears top, R3 high form keeps bottom
    apply("R2 low form", {32'h41200000, 32'hBF800000, 32'h3F808001, 32'h447A0000}, oldPat, 0, 1, 0, 0);
    check("R2 top zero", {64'd0, newDst[127:64]}, 128'd0);
    apply("R3 high form", {32'h41200000, 32'hBF800000, 32'h3F808001, 32'h447A0000}, oldPat, 1, 1, 0, 0);
    check("R3 bottom kept", {64'd0, newDst[63:0]}, {64'd0, oldPat[63:0]});
    // R4 feature disabled
    apply("R4 disabled low", {32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, oldPat, 0, 0, 0, 0);
    check("R4 dst held", newDst, oldPat);
    apply("R4 disabled high", {4{32'h40490FDB}}, ~oldPat, 1, 0, 1, 1);
    // R5 nearest-even ties and near-ties
    apply("R5 ties", {32'h3F807FFF, 32'h3F808001, 32'h3F818000, 32'h3F808000}, oldPat, 0, 1, 0, 0);
    check("R5 literal", newDst, {64'd0, 64'h3F80_3F81_3F82_3F80});
    // R6 toward zero
    apply("R6 truncate", {32'h3F807FFF, 32'hBF80FFFF, 32'h3F818000, 32'h7F7FFFFF}, oldPat, 0, 1, 1, 0);
    check("R6 literal", newDst, {64'd0, 64'h3F80_BF80_3F81_7F7F});
    // R7 NaN
    apply("R7 nan", {32'h7FFFFFFF, 32'hFF800001, 32'h7FC00000, 32'h7F812345}, oldPat, 1, 1, 0, 0);
    check("R7 literal", {64'd0, newDst[127:64]}, {64'd0, 64'h7FFF_FFC0_7FC0_7FC1});
    // R8 inf and zero
    apply("R8 exact", {32'h7F800000, 32'hFF800000, 32'h00000000, 32'h80000000}, oldPat, 0, 1, 0, 1);
    check("R8 literal", newDst, {64'd0, 64'h7F80_FF80_0000_8000});
    // R9 overflow
    apply("R9 overflow", {32'h7F7FFFFF, 32'hFF7FFFFF, 32'h7F7F8000, 32'h7F7F7FFF}, oldPat, 0, 1, 0, 0);
    check("R9 literal", newDst, {64'd0, 64'h7F80_FF80_7F80_7F7F});
    // R10 denormals
    apply("R10 flush", {32'h00400000, 32'h80018000, 32'h007FFFFF, 32'h00000001}, oldPat, 0, 1, 0, 1);
    check("R10 flush literal", newDst, {64'd0, 64'h0000_8000_0000_0000});
    apply("R10 rounded", {32'h00018000, 32'h80018000, 32'h007FFFFF, 32'h00008001}, oldPat, 0, 1, 0, 0);
    check("R10 rounded literal", newDst, {64'd0, 64'h0002_8002_0080_0001});
    // R11 idle cycle drops valid and holds data
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 idle valid", {127'd0, outValid}, 128'd0);
    check("R11 idle undef", {127'd0, undefOp}, 128'd0);
    check("R11 idle hold", newDst, {64'd0, 64'h0002_8002_0080_0001});

    // R1 random mix with special lanes
    for (int it = 0; it < 400; it++) begin
      logic [127:0] src;
      logic [127:0] old;
      for (int e = 0; e < 4; e++) begin
        logic [31:0] w;
        w = $urandom;
        case ($urandom % 8)
          0: w[30:23] = 8'hFF;
          1: w[30:23] = 8'h00;
          2: w[15:0] = 16'h8000;
          3: w[30:16] = 15'h7F7F;
          default: ;
        endcase
        src[e*32 +: 32] = w;
      end
      old = {$urandom, $urandom, $urandom, $urandom};
      apply("R1 random", src, old, 1'($urandom), ($urandom % 8) != 0, 1'($urandom), 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule